// File: doc/BRIEF.md
# Sliding integral image window updater

This block holds a square window of integral image values in a register array. A strip of rows is scanned from left to right, one pixel column per step. On each step every row of the array moves one column toward index 0. Each row is also rebased: it subtracts a row offset a_j from its stored values, so the values stay small instead of growing along the scan. A freshly computed integral column is then written into the last position. A detector downstream reads the whole array. It forms rectangle sums from four corners that lie in the same two rows. Because each row loses the same offset from every element, those sums do not change.

The offset for row j is the value at column 1 of that row before the step, with its s_j low bits forced to zero. After the step, the value at column 0 is therefore smaller than 2^s_j. A fixed per-row width is derived from s_j and the worst case growth along the row, and every stored value fits in that width. The array is cleared at the start of each strip. The valid flag goes high once a full window of columns has been shifted in.

Top module: `hwin_slide_integ`

## Requirements
- R1: While reset is asserted and after it is released, every window element reads 0 and `win_valid_o` is low.
- R2: A cycle with `row_start_i` high sets every element to 0 and drops `win_valid_o` at the next clock edge. A `step_i` in that same cycle has no effect.
- R3: In a cycle with `step_i` and `row_start_i` both low, no window element and no valid flag changes.
- R4: On a step, the new element (i,j) equals the old element (i+1,j) minus a_j, for i from 0 to W-2.
- R5: a_j equals the old element (1,j) with its s_j least significant bits cleared, where s_j = ceil(log2((j+1)*(2^P-1))). With the defaults this gives s_j = 8 for row 0 and s_j = 13 for row 19.
- R6: On a step, the new element (W-1,j) equals the old element (W-1,j) minus a_j plus the sum of incoming pixels 0..j. Pixel k of the column is `pix_col_i[k*P +: P]`, unsigned.
- R7: Within a row, the difference between elements i and 0 always equals the difference between the true integral values at those two columns.
- R8: After any step, element (0,j) is below 2^s_j. Every row is nondecreasing along i, and every element fits in OW bits (17 with the defaults).
- R9: `win_valid_o` goes high at the edge of the W-th step after a clear or reset, and stays high until the next clear.
- R10: Element (i,j) appears zero-extended at `win_o[(j*W+i)*OW +: OW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| row_start_i | input | 1 | Clears the window at the start of a strip |
| step_i | input | 1 | Moves the window one column and accepts `pix_col_i` |
| pix_col_i | input | H*P | Incoming pixel column, pixel k in bits k*P and up |
| win_o | output | W*H*OW | Whole window array, OW bits per element |
| win_valid_o | output | 1 | A full window of columns has been shifted in |

## Verification
The window array and the valid flag are registers. A step or a clear presented in one cycle is therefore visible at the clock edge that samples it, and not before. The bench drives inputs on the falling edge and reads the results on the next falling edge. This puts each check exactly one edge after its stimulus. After reset is released, the two-flop reset release adds two edges, and the bench waits past them before the first step. Idle cycles are checked on the falling edge after each idle rising edge, to show that nothing moved.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

  // Largest pixel value for a pixel width of p bits.
  function automatic int pix_max(int p);
    return (1 << p) - 1;
  endfunction

  // Number of low bits cleared from the row offset of row j.
  function automatic int sh_bits(int j, int p);
    return $clog2((j + 1) * pix_max(p));
  endfunction

  // Stored width of row j: head below 2^s plus growth over w-1 columns.
  function automatic int row_bits(int j, int w, int p);
    return $clog2((1 << sh_bits(j, p)) + (w - 1) * (j + 1) * pix_max(p) + 1);
  endfunction

  // Width of a prefix column sum over h pixels.
  function automatic int csum_bits(int h, int p);
    return $clog2(h * pix_max(p) + 1);
  endfunction

endpackage

// File: rtl/hwin_colsum.sv
module hwin_colsum
  import hwin_pkg::*;
#(
  parameter int H  = 20,
  parameter int P  = 8,
  parameter int CW = csum_bits(H, P)
) (
  input  logic [H*P-1:0]  pix_col_i,
  output logic [H*CW-1:0] csum_o
);

  logic [CW-1:0] acc;

  // Running sum down the column: entry k holds pixels 0..k.
  always_comb begin
    acc = '0;
    for (int k = 0; k < H; k++) begin
      acc = acc + CW'(pix_col_i[k*P +: P]);
      csum_o[k*CW +: CW] = acc;
    end
  end

endmodule

// File: rtl/hwin_row.sv
module hwin_row
  import hwin_pkg::*;
#(
  parameter int W  = 20,
  parameter int P  = 8,
  parameter int J  = 0,
  parameter int CW = 13,
  parameter int OW = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [CW-1:0]   csum_i,
  output logic [W*OW-1:0] row_o
);

  localparam int S  = sh_bits(J, P);
  localparam int RW = row_bits(J, W, P);
  localparam int EW = ((RW > CW) ? RW : CW) + 1;
  localparam logic [RW:0] HEAD_LIM = (RW+1)'(1) << S;

  logic [RW-1:0] cur_q [W];
  logic [RW-1:0] cur_d [W];
  logic [EW-1:0] ext_d [W];
  logic [RW-1:0] off;
  logic          en;

  assign en  = clr_i | step_i;
  assign off = {cur_q[1][RW-1:S], {S{1'b0}}};

  // Rebased shift, with the new column appended at the end.
  always_comb begin
    for (int i = 0; i < W - 1; i++) begin
      ext_d[i] = EW'(cur_q[i+1]) - EW'(off);
    end
    ext_d[W-1] = EW'(cur_q[W-1]) - EW'(off) + EW'(csum_i);
    for (int i = 0; i < W; i++) begin
      if (clr_i) begin
        cur_d[i] = '0;
      end else begin
        cur_d[i] = ext_d[i][RW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < W; i++) cur_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < W; i++) cur_q[i] <= cur_d[i];
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    assign row_o[i*OW +: OW] = OW'(cur_q[i]);
  end

  // Width budget: no rebased value needs more than the row width.
  for (genvar i = 0; i < W; i++) begin : g_fit
    AST_ROW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i) |-> (ext_d[i][EW-1:RW] == '0)); // R8
  end

  for (genvar i = 0; i < W - 1; i++) begin : g_mono
    AST_ROW_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q[i] <= cur_q[i+1]); // R8
  end

  AST_HEAD_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> ({1'b0, cur_q[0]} < HEAD_LIM)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cur_q[W-1] == '0 && cur_q[0] == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cur_q[W-1])); // R3

endmodule

// File: rtl/hwin_fill.sv
module hwin_fill #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic valid_o
);

  localparam int NW = $clog2(W + 1);
  localparam logic [NW-1:0] FULL = NW'(W);

  logic [NW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = clr_i | (step_i && cnt_q != FULL);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign valid_o = (cnt_q == FULL);

  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !valid_o); // R2

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> ($past(step_i) && !$past(clr_i))); // R9

  AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !clr_i) |=> valid_o); // R9

endmodule

// File: rtl/hwin_slide_integ.sv
module hwin_slide_integ
  import hwin_pkg::*;
#(
  parameter int W  = 20,
  parameter int H  = 20,
  parameter int P  = 8,
  parameter int OW = row_bits(H - 1, W, P)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_start_i,
  input  logic              step_i,
  input  logic [H*P-1:0]    pix_col_i,
  output logic [W*H*OW-1:0] win_o,
  output logic              win_valid_o
);

  localparam int CW = csum_bits(H, P);

  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic [H*CW-1:0] csum;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  hwin_colsum #(.H(H), .P(P), .CW(CW)) u_colsum (
    .pix_col_i (pix_col_i),
    .csum_o    (csum)
  );

  for (genvar j = 0; j < H; j++) begin : g_row
    hwin_row #(.W(W), .P(P), .J(j), .CW(CW), .OW(OW)) u_row (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .clr_i  (row_start_i),
      .step_i (step_i),
      .csum_i (csum[j*CW +: CW]),
      .row_o  (win_o[j*W*OW +: W*OW])
    );
  end

  hwin_fill #(.W(W)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (row_start_i),
    .step_i  (step_i),
    .valid_o (win_valid_o)
  );

endmodule

// File: tb/sim_hwin_slide_integ.sv
module sim_hwin_slide_integ;

  localparam int W = 20;
  localparam int H = 20;
  localparam int P = 8;
  localparam int PM = (1 << P) - 1;

  function automatic int s_of(int j);
    return $clog2((j + 1) * PM);
  endfunction

  localparam int OW = $clog2((1 << s_of(H-1)) + (W-1)*H*PM + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              row_start_i;
  logic              step_i;
  logic [H*P-1:0]    pix_col_i;
  logic [W*H*OW-1:0] win_o;
  logic              win_valid_o;

  hwin_slide_integ #(.W(W), .H(H), .P(P)) u0 (
    .clk(clk), .rst_n(rst_n), .row_start_i(row_start_i), .step_i(step_i),
    .pix_col_i(pix_col_i), .win_o(win_o), .win_valid_o(win_valid_o)
  );

  always #2.5 clk = ~clk;

  longint m   [W][H];   // expected stored values
  longint ab  [W][H];   // true integral values per window column
  longint px  [H];
  int     cnt_m;
  int     vecs = 0;
  int     bad  = 0;
  bit     done = 0;
  int unsigned lfsr = 32'h1ACE_B00C;

  function automatic longint elem(int i, int j);
    return longint'(win_o[(j*W+i)*OW +: OW]);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < W; i++)
      for (int j = 0; j < H; j++) begin m[i][j] = 0; ab[i][j] = 0; end
    cnt_m = 0;
  endtask

  task automatic model_step();
    longint cs, a, last, abl;
    cs = 0;
    for (int j = 0; j < H; j++) begin
      cs   = cs + px[j];
      a    = m[1][j] & ~((longint'(1) << s_of(j)) - 1);
      last = m[W-1][j];
      abl  = ab[W-1][j];
      for (int i = 0; i < W - 1; i++) begin
        m[i][j]  = m[i+1][j] - a;
        ab[i][j] = ab[i+1][j];
      end
      m[W-1][j]  = last - a + cs;
      ab[W-1][j] = abl + cs;
    end
    if (cnt_m < W) cnt_m++;
  endtask

  // Compare the whole window against the model (sampled at negedge).
  task automatic check_all(string tag);
    int e_exact, e_rel, e_head;
    e_exact = 0; e_rel = 0; e_head = 0;
    for (int j = 0; j < H; j++) begin
      for (int i = 0; i < W; i++) begin
        if (elem(i, j) != m[i][j]) begin
          if (e_exact == 0)
            $display("FAIL R4/R5/R6/R10 %s elem(%0d,%0d) got %0d exp %0d",
                     tag, i, j, elem(i, j), m[i][j]);
          e_exact++;
        end
        if ((elem(i, j) - elem(0, j)) != (ab[i][j] - ab[0][j])) begin
          if (e_rel == 0)
            $display("FAIL R7 %s diff(%0d,%0d) got %0d exp %0d", tag, i, j,
                     elem(i, j) - elem(0, j), ab[i][j] - ab[0][j]);
          e_rel++;
        end
      end
      if (elem(0, j) >= (longint'(1) << s_of(j))) begin
        if (e_head == 0)
          $display("FAIL R8 %s head row %0d got %0d exp below %0d", tag, j,
                   elem(0, j), longint'(1) << s_of(j));
        e_head++;
      end
    end
    vecs += 4;
    if (e_exact != 0) bad++;
    if (e_rel != 0)   bad++;
    if (e_head != 0)  bad++;
    if (win_valid_o !== (cnt_m == W)) begin
      $display("FAIL R9 %s valid got %0b exp %0b", tag, win_valid_o, cnt_m == W);
      bad++;
    end
  endtask

  // mode 0 zeros, 1 max, 2 ramp, 3 pseudo-random
  task automatic make_col(int mode, int n);
    for (int j = 0; j < H; j++) begin
      case (mode)
        0: px[j] = 0;
        1: px[j] = PM;
        2: px[j] = (n * 7 + j * 13) % (PM + 1);
        default: begin
          lfsr  = lfsr * 32'd1664525 + 32'd1013904223;
          px[j] = (lfsr >> 16) & PM;
        end
      endcase
      pix_col_i[j*P +: P] = P'(px[j]);
    end
  endtask

  task automatic do_step(int mode, int n, string tag);
    make_col(mode, n);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    model_step();
    check_all(tag);
  endtask

  task automatic do_clear(bit with_step, string tag);
    make_col(1, 0);
    row_start_i = 1'b1;
    step_i      = with_step;
    @(negedge clk);
    row_start_i = 1'b0;
    step_i      = 1'b0;
    model_clear();
    check_all(tag);   // R2
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; row_start_i = 1'b0; step_i = 1'b0; pix_col_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    do_clear(1'b0, "R2 clear");
    // Fill with maximum pixels: valid must rise on step W, not W-1 (R9).
    for (int n = 0; n < W + 25; n++) do_step(1, n, "R9/R8 max fill");
    // Idle cycles: nothing moves (R3).
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check_all("R3 idle");
    end
    // Clear together with a step: step ignored (R2).
    do_clear(1'b1, "R2 clear with step");
    for (int n = 0; n < 30; n++) do_step(2, n, "R4 ramp");
    for (int n = 0; n < 10; n++) do_step(0, n, "R6 zero columns");
    do_clear(1'b0, "R2 mid-strip clear");
    for (int n = 0; n < 250; n++) begin
      do_step(3, n, "R5/R7 random");
      if (n % 37 == 36) begin
        @(negedge clk);
        check_all("R3 gap");
      end
    end
    do_clear(1'b1, "R2 final clear");
    for (int n = 0; n < W - 1; n++) do_step(3, n, "R9 partial fill");
    do_step(1, 0, "R9 last fill step");
    do_step(0, 1, "R10 layout after fill");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule